// File: doc/BRIEF.md
# Calendar Time-of-Day Keeper

This block keeps a running calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Software reads and writes the time through a small byte-wide register port. A prescaler divides the core clock down to a one-second tick. On every tick the binary calendar counter advances, and the block raises an update-in-progress status flag. A fixed number of cycles later the update window closes. At that point the new count is encoded and copied into the visible time registers, and a one-cycle completion pulse is sent to the interrupt logic.

Two control bits choose how the visible registers hold time. One bit selects binary or packed-BCD encoding. The other selects 24-hour mode or 12-hour mode, where the 12-hour mode carries a PM flag. A set-mode bit freezes the visible registers so software can write a complete new time without it moving underneath. When set mode is released, the internal counter reloads from what software wrote. Outside set mode, any write to a time register reloads the counter at once.

The register port has no handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data follows `reg_addr` combinationally.

Top module: `tod_keeper`

## Requirements
- R1: Time advances only while bits 6:4 of the divider/status register (address 0xA) equal 3'b010. With any other value, no second is counted, update-in-progress stays low and no completion pulse appears.
- R2: Bit 2 of the control register (address 0xB) selects the data mode. When it is 1, every time byte is plain binary. When it is 0, every time byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R3: Bit 1 of the control register selects 24-hour mode when it is 1. When it is 0, the hour byte holds the hour modulo 12 in bits 6:0 (so noon and midnight read as 0), and bit 7 is set for hours 12 to 23.
- R4: Bit 7 of register 0xA is the update-in-progress flag, and it is read-only. A write to 0xA stores bits 6:0 and leaves bit 7 as it was.
- R5: On each counted second tick, update-in-progress rises, but only when set mode is off. It stays high for UPDATE_CYCLES clocks. When the window closes, the flag is cleared and the visible registers take the new time. At the same point `upd_done` pulses for exactly one clock, and `upd_irq` pulses with it when bit 4 of the control register is 1.
- R6: A write to the control register with bit 7 (set mode) at 1 clears update-in-progress and stores bit 4 as 0, whatever was written to it.
- R7: While set mode is on, completed updates do not change the visible time registers, software writes to them are kept, and update-in-progress never rises.
- R8: With set mode off, a write to a time register reloads the internal counter from the visible registers, including the new byte. The next update then shows the written time plus one second.
- R9: A control-register write that takes set mode from on to off reloads the counter from the visible registers. The data and hour modes used are the ones in that write.
- R10: Register addresses are: seconds 0, minutes 2, hours 4, day of week 6, day of month 7, month 8, year 9, divider/status 0xA, control 0xB, validity 0xD. After reset, 0xA reads 0x26, 0xB reads 0x02, 0xD reads 0x80, and the time reads 00:00:00, weekday 1, 01/01, year 00. All other addresses read 0, and writes to them are ignored.
- R11: The calendar rolls over as follows. Seconds and minutes wrap at 60. Hours wrap at 24. Day of week runs 1 to 7 and then back to 1. Day of month wraps to 1 after the last day of the month: 30 for months 4, 6, 9 and 11, 31 for the other long months, and for February 29 when the year is divisible by 4 and 28 otherwise. Month wraps from 12 to 1, and at that rollover the year wraps from 99 to 0.
- R12: When a counter reload falls in the same cycle as a second tick, the reload wins and that tick's increment is lost. The update window still runs, and it then publishes the reloaded time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| upd_done | output | 1 | One-clock pulse when an update window closes |
| upd_irq | output | 1 | `upd_done` gated by the update-ended enable |

## Verification
The two functions that can fall in the same cycle are a software reload of the counter and the second tick that increments it. The bench measures the tick position from an observed completion pulse. It then issues a seconds write timed to land exactly on the next tick edge. The check passes only if the following update shows the written value unchanged, rather than that value plus one (R12). A write landing just after a pulse, away from any tick, is also checked and must show the value plus one. This contrast shows that the two cases really differ.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned NFIELD = 7;
  localparam int unsigned FIDX_W = 3;

  localparam logic [3:0] ADR_SEC  = 4'h0;
  localparam logic [3:0] ADR_MIN  = 4'h2;
  localparam logic [3:0] ADR_HR   = 4'h4;
  localparam logic [3:0] ADR_WDAY = 4'h6;
  localparam logic [3:0] ADR_MDAY = 4'h7;
  localparam logic [3:0] ADR_MON  = 4'h8;
  localparam logic [3:0] ADR_YR   = 4'h9;
  localparam logic [3:0] ADR_DIV  = 4'hA;
  localparam logic [3:0] ADR_CTL  = 4'hB;
  localparam logic [3:0] ADR_VLD  = 4'hD;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HR   = 2;
  localparam int unsigned F_WDAY = 3;
  localparam int unsigned F_MDAY = 4;
  localparam int unsigned F_MON  = 5;
  localparam int unsigned F_YR   = 6;

  localparam int unsigned CTL_SET  = 7;
  localparam int unsigned CTL_UIE  = 4;
  localparam int unsigned CTL_BIN  = 2;
  localparam int unsigned CTL_H24  = 1;

  localparam logic [2:0] DIV_RUN = 3'b010;

  typedef struct packed {
    logic [6:0] yr;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hr;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  typedef logic [NFIELD-1:0][7:0] vis_t;

  function automatic logic [7:0] val_to_code(input logic [6:0] v, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v - tens * 7'd10;
    if (bin) return {1'b0, v};
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] code_to_val(input logic [7:0] b, input logic bin);
    logic [7:0] t;
    if (bin) t = b;
    else t = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    return t[6:0];
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] mon, input logic [6:0] yr);
    case (mon)
      4'd2:                       return (yr[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    return 5'd30;
      default:                    return 5'd31;
    endcase
  endfunction

  function automatic logic [FIDX_W:0] addr_field(input logic [3:0] a);
    case (a)
      ADR_SEC:  return {1'b1, 3'd0};
      ADR_MIN:  return {1'b1, 3'd1};
      ADR_HR:   return {1'b1, 3'd2};
      ADR_WDAY: return {1'b1, 3'd3};
      ADR_MDAY: return {1'b1, 3'd4};
      ADR_MON:  return {1'b1, 3'd5};
      ADR_YR:   return {1'b1, 3'd6};
      default:  return {1'b0, 3'd0};
    endcase
  endfunction

endpackage

// File: rtl/tod_second_gen.sv
module tod_second_gen #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UPDATE_CYCLES = 32440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic start_o,
  output logic fin_o
);
  localparam int unsigned CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int unsigned WW = (UPDATE_CYCLES > 1) ? $clog2(UPDATE_CYCLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(TICKS_PER_SEC - 1);
  localparam logic [WW-1:0] WMAX = WW'(UPDATE_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] wcnt;
  logic          busy;
  logic          tick;

  assign tick    = (cnt == CMAX);
  assign start_o = tick && run_i;
  assign fin_o   = busy && (wcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wcnt <= '0;
    end else if (start_o) begin
      busy <= 1'b1;
      wcnt <= WMAX;
    end else if (fin_o) begin
      busy <= 1'b0;
    end else if (busy) begin
      wcnt <= wcnt - 1'b1;
    end
  end

  initial begin
    if (UPDATE_CYCLES < 1 || UPDATE_CYCLES >= TICKS_PER_SEC)
      $error("update window must be shorter than one second");
  end

  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !busy) |=> !busy); // R1
  AST_FIN_ENDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o); // R5
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  cal_t load_val_i,
  input  logic step_i,
  output cal_t cal_o
);
  cal_t cur;
  cal_t nxt;
  logic [4:0] dim;

  assign dim   = month_days(cur.mon, cur.yr);
  assign cal_o = cur;

  always_comb begin
    nxt = cur;
    if (cur.sec >= 6'd59) begin
      nxt.sec = '0;
      if (cur.min >= 6'd59) begin
        nxt.min = '0;
        if (cur.hr >= 5'd23) begin
          nxt.hr = '0;
          nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
          if (cur.mday >= dim) begin
            nxt.mday = 5'd1;
            if (cur.mon >= 4'd12) begin
              nxt.mon = 4'd1;
              nxt.yr  = (cur.yr >= 7'd99) ? 7'd0 : cur.yr + 7'd1;
            end else begin
              nxt.mon = cur.mon + 4'd1;
            end
          end else begin
            nxt.mday = cur.mday + 5'd1;
          end
        end else begin
          nxt.hr = cur.hr + 5'd1;
        end
      end else begin
        nxt.min = cur.min + 6'd1;
      end
    end else begin
      nxt.sec = cur.sec + 6'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '{yr: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1, hr: 5'd0, min: 6'd0, sec: 6'd0};
    end else if (load_i) begin
      cur <= load_val_i;
    end else if (step_i) begin
      cur <= nxt;
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cur == $past(load_val_i))); // R12
endmodule

// File: rtl/tod_encode.sv
module tod_encode
  import tod_pkg::*;
(
  input  cal_t cal_i,
  input  logic bin_i,
  input  logic h24_i,
  output vis_t code_o
);
  logic [NFIELD-1:0][6:0] fv;
  logic                   pm;
  logic [6:0]             h12;

  assign fv[F_SEC]  = {1'b0, cal_i.sec};
  assign fv[F_MIN]  = {1'b0, cal_i.min};
  assign fv[F_HR]   = {2'b0, cal_i.hr};
  assign fv[F_WDAY] = {4'b0, cal_i.wday};
  assign fv[F_MDAY] = {2'b0, cal_i.mday};
  assign fv[F_MON]  = {3'b0, cal_i.mon};
  assign fv[F_YR]   = cal_i.yr;

  assign pm  = (cal_i.hr >= 5'd12);
  assign h12 = pm ? fv[F_HR] - 7'd12 : fv[F_HR];

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    if (i == F_HR) begin : g_hr
      assign code_o[i] = h24_i ? val_to_code(fv[i], bin_i)
                               : (val_to_code(h12, bin_i) | {pm, 7'd0});
    end else begin : g_plain
      assign code_o[i] = val_to_code(fv[i], bin_i);
    end
  end
endmodule

// File: rtl/tod_decode.sv
module tod_decode
  import tod_pkg::*;
(
  input  vis_t code_i,
  input  logic bin_i,
  input  logic h24_i,
  output cal_t cal_o
);
  logic [NFIELD-1:0][6:0] fv;
  logic [6:0]             hraw;
  logic [6:0]             hr;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign fv[i] = code_to_val(code_i[i], bin_i);
  end

  assign hraw = code_to_val({1'b0, code_i[F_HR][6:0]}, bin_i);
  assign hr   = h24_i ? fv[F_HR] : (code_i[F_HR][7] ? hraw + 7'd12 : hraw);

  assign cal_o.sec  = fv[F_SEC][5:0];
  assign cal_o.min  = fv[F_MIN][5:0];
  assign cal_o.hr   = hr[4:0];
  assign cal_o.wday = fv[F_WDAY][2:0];
  assign cal_o.mday = fv[F_MDAY][4:0];
  assign cal_o.mon  = fv[F_MON][3:0];
  assign cal_o.yr   = fv[F_YR];
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UPDATE_CYCLES = 32440
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       upd_done,
  output logic       upd_irq
);
  localparam logic [7:0] DIV_RST = 8'h26;
  localparam logic [7:0] CTL_RST = 8'h02;
  localparam logic [7:0] VLD_VAL = 8'h80;

  logic [6:0] div_q;
  logic       uip;
  logic [7:0] ctl_q;
  vis_t       vis;
  vis_t       vis_n;
  vis_t       enc;
  cal_t       cal;
  cal_t       dec;

  logic [FIDX_W:0] wsel;
  logic            wr_time;
  logic            wr_div;
  logic            wr_ctl;
  logic [7:0]      ctl_n;
  logic            load;
  logic            run;
  logic            start;
  logic            fin;
  logic            done_q;
  logic            irq_q;

  assign wsel    = addr_field(reg_addr);
  assign wr_time = reg_wr && wsel[FIDX_W];
  assign wr_div  = reg_wr && (reg_addr == ADR_DIV);
  assign wr_ctl  = reg_wr && (reg_addr == ADR_CTL);
  assign run     = (div_q[6:4] == DIV_RUN);

  always_comb begin
    ctl_n = ctl_q;
    if (wr_ctl) begin
      ctl_n = reg_wdata;
      if (reg_wdata[CTL_SET]) ctl_n[CTL_UIE] = 1'b0;
    end
  end

  always_comb begin
    vis_n = vis;
    if (wr_time) vis_n[wsel[FIDX_W-1:0]] = reg_wdata;
  end

  assign load = (wr_time && !ctl_q[CTL_SET]) ||
                (wr_ctl && !reg_wdata[CTL_SET] && ctl_q[CTL_SET]);

  tod_second_gen #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UPDATE_CYCLES(UPDATE_CYCLES)
  ) u_sec (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run),
    .start_o (start),
    .fin_o   (fin)
  );

  tod_decode u_dec (
    .code_i (vis_n),
    .bin_i  (ctl_n[CTL_BIN]),
    .h24_i  (ctl_n[CTL_H24]),
    .cal_o  (dec)
  );

  tod_calendar u_cal (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (dec),
    .step_i     (start && !load),
    .cal_o      (cal)
  );

  tod_encode u_enc (
    .cal_i  (cal),
    .bin_i  (ctl_q[CTL_BIN]),
    .h24_i  (ctl_q[CTL_H24]),
    .code_o (enc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    end else begin
      if (fin && !ctl_q[CTL_SET]) vis <= enc;
      if (wr_time) vis[wsel[FIDX_W-1:0]] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_RST[6:0];
      uip   <= DIV_RST[7];
      ctl_q <= CTL_RST;
    end else begin
      if (wr_div) div_q <= reg_wdata[6:0];
      ctl_q <= ctl_n;
      if (wr_ctl && reg_wdata[CTL_SET]) uip <= 1'b0;
      else if (fin) uip <= 1'b0;
      else if (start && !ctl_q[CTL_SET]) uip <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= fin;
      irq_q  <= fin && ctl_q[CTL_UIE];
    end
  end

  assign upd_done = done_q;
  assign upd_irq  = irq_q;

  always_comb begin
    reg_rdata = 8'h00;
    if (wsel[FIDX_W]) reg_rdata = vis[wsel[FIDX_W-1:0]];
    else begin
      case (reg_addr)
        ADR_DIV: reg_rdata = {uip, div_q};
        ADR_CTL: reg_rdata = ctl_q;
        ADR_VLD: reg_rdata = VLD_VAL;
        default: reg_rdata = 8'h00;
      endcase
    end
  end

  AST_UIP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div && !start && !fin) |=> (uip == $past(uip))); // R4
  AST_SET_CLEARS_UIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && reg_wdata[CTL_SET]) |=> (!uip && !ctl_q[CTL_UIE])); // R6
  AST_SET_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_SET] && !reg_wr) |=> $stable(vis)); // R7
  AST_NO_UIP_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_SET] && !uip) |=> !uip); // R7
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done); // R5
  AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_irq |-> upd_done); // R5
endmodule

// File: tb/tod_keeper_test.sv
module tod_keeper_test;
  localparam int TPS = 20;
  localparam int UPD = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       upd_done;
  logic       upd_irq;

  int n_run = 0;
  int n_fail = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  tod_keeper #(.TICKS_PER_SEC(TPS), .UPDATE_CYCLES(UPD)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .upd_done(upd_done), .upd_irq(upd_irq)
  );

  function automatic int benc(int v, bit bin);
    return bin ? v : ((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int benc_hr(int h, bit bin, bit h24);
    if (h24) return benc(h, bin);
    return benc(h % 12, bin) | ((h >= 12) ? 128 : 0);
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!upd_done);
  endtask

  task automatic set_time(int s, int mi, int h, int wd, int md, int mo, int y);
    wr(4'hB, 8'h82);
    wr(4'h0, 8'(benc(s, 0)));  wr(4'h2, 8'(benc(mi, 0)));
    wr(4'h4, 8'(benc(h, 0)));  wr(4'h6, 8'(benc(wd, 0)));
    wr(4'h7, 8'(benc(md, 0))); wr(4'h8, 8'(benc(mo, 0)));
    wr(4'h9, 8'(benc(y, 0)));
    wait_done();
    wr(4'hB, 8'h02);
    wait_done();
  endtask

  task automatic check_date(string req, int wd, int md, int mo, int y);
    int v;
    rd(4'h6, v); check(req, v, benc(wd, 0));
    rd(4'h7, v); check(req, v, benc(md, 0));
    rd(4'h8, v); check(req, v, benc(mo, 0));
    rd(4'h9, v); check(req, v, benc(y, 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    rd(4'hA, v); check("R10 div", v, 8'h26);
    rd(4'hB, v); check("R10 ctl", v, 8'h02);
    rd(4'hD, v); check("R10 vld", v, 8'h80);
    rd(4'h0, v); check("R10 sec", v, 0);
    rd(4'h4, v); check("R10 hr", v, 0);
    check_date("R10 date", 1, 1, 1, 0);
    wr(4'h3, 8'h55);
    rd(4'h3, v); check("R10 unused addr", v, 0);

    // R5 first update and pulse width
    wait_done();
    check("R5 irq off", int'(upd_irq), 0);
    rd(4'h0, v); check("R5 sec step", v, 1);
    check("R5 pulse one clock", int'(upd_done), 0);

    // R5 / R4 update-in-progress window, read-only bit
    cnt = 0;
    do begin rd(4'hA, v); cnt++; end while (!v[7] && cnt < 40);
    check("R5 uip rises", v & 8'h80, 8'h80);
    rd(4'h0, v); check("R5 regs held during window", v, 1);
    wr(4'hA, 8'h26);
    rd(4'hA, v); check("R4 uip kept on write", v, 8'hA6);
    // R6 set mode clears uip and update-ended enable
    wr(4'hB, 8'h92);
    rd(4'hA, v); check("R6 uip cleared", v, 8'h26);
    rd(4'hB, v); check("R6 uie forced 0", v, 8'h82);
    // R7 freeze: no uip and no copy
    wr(4'h0, 8'h42);
    cnt = 0;
    for (int i = 0; i < TPS + 4; i++) begin
      rd(4'hA, v); if (v[7]) cnt++;
    end
    check("R7 no uip in set mode", cnt, 0);
    wait_done();
    rd(4'h0, v); check("R7 written sec kept", v, 8'h42);
    wr(4'hA, 8'hA6);
    rd(4'hA, v); check("R4 uip not writable", v & 8'h80, 0);
    wr(4'hB, 8'h02);
    wait_done();
    rd(4'h0, v); check("R9 reload on set release", v, 8'h43);

    // R11 calendar rollovers
    set_time(59, 59, 23, 7, 28, 2, 3);
    rd(4'h0, v); check("R11 sec wrap", v, 0);
    rd(4'h2, v); check("R11 min wrap", v, 0);
    rd(4'h4, v); check("R11 hr wrap", v, 0);
    check_date("R11 feb non-leap", 1, 1, 3, 3);
    set_time(59, 59, 23, 3, 28, 2, 4);
    check_date("R11 feb leap", 4, 29, 2, 4);
    set_time(59, 59, 23, 5, 30, 4, 10);
    check_date("R11 30-day month", 6, 1, 5, 10);
    set_time(59, 59, 23, 2, 31, 12, 99);
    check_date("R11 year wrap", 3, 1, 1, 0);

    // R8 immediate load, then R12 load colliding with tick
    wait_done();
    wr(4'h0, 8'h10);
    wait_done();
    rd(4'h0, v); check("R8 load then count", v, 8'h11);
    wait_done();
    repeat (TPS - UPD - 1) @(negedge clk);
    wr(4'h0, 8'h30);
    wait_done();
    rd(4'h0, v); check("R12 reload wins over tick", v, 8'h30);

    // R5 interrupt pulse with enable
    wr(4'hB, 8'h12);
    wait_done();
    check("R5 irq pulse", int'(upd_irq), 1);
    wr(4'hB, 8'h02);

    // R1 divider stopped
    wait_done();
    wr(4'hA, 8'h06);
    rd(4'h0, v);
    cnt = 0;
    for (int i = 0; i < 3 * TPS; i++) begin
      @(negedge clk); if (upd_done) cnt++;
    end
    check("R1 no update when stopped", cnt, 0);
    begin int s2; rd(4'h0, s2); check("R1 time held", s2, v); end
    wr(4'hA, 8'h26);

    // R2 / R3 sweep of all hours in every mode
    for (int m = 0; m < 4; m++) begin
      for (int h = 0; h < 24; h++) begin
        bit bin, h24;
        bin = m[0]; h24 = m[1];
        wr(4'hB, 8'(8'h80 | (bin ? 8'h04 : 8'h00) | (h24 ? 8'h02 : 8'h00)));
        wr(4'h0, 8'(benc(59, bin)));
        wr(4'h2, 8'(benc(59, bin)));
        wr(4'h4, 8'(benc_hr(h, bin, h24)));
        wait_done();
        wr(4'hB, 8'((bin ? 8'h04 : 8'h00) | (h24 ? 8'h02 : 8'h00)));
        wait_done();
        rd(4'h4, v); check(h24 ? "R3 hour 24h" : "R3 hour 12h", v, benc_hr((h + 1) % 24, bin, h24));
        rd(4'h2, v); check(bin ? "R2 binary min" : "R2 bcd min", v, 0);
        rd(4'h0, v); check(bin ? "R2 binary sec" : "R2 bcd sec", v, benc(0, bin));
      end
    end
    wr(4'hB, 8'h06);
    wait_done();
    wr(4'h0, 8'd45);
    wait_done();
    rd(4'h0, v); check("R2 binary count", v, 46);

    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule